// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is a management-bus master for Ethernet PHYs. Software places one PHY register access into a single 32-bit command word. The word carries a start flag, a direction bit, the PHY and register addresses and a 16-bit data value. The block sends the request as a Clause 22 management frame on MDC/MDIO, using a tri-state data pin. On a read it captures the data returned by the PHY and records whether the PHY answered. When the frame is over it drops the start flag, so software can poll that flag to see when the access has finished.

MDC is derived from the system clock by a parameterised divider. The frame does not begin on the cycle of the bus write. It begins at the next MDC low phase. While an access is pending or running, the command word is locked against bus writes, so the frame always uses the values that software queued.

Top module: `mdio_user_ctrl`

## Requirements
- R1: After reset the command word reads all zeros, MDC is low, and MDIO is released (output enable 0, data out 1).
- R2: Command word layout: bit 31 start flag, bit 30 direction (1 = write), bit 29 PHY-answered flag, bits 25:21 register address, bits 20:16 PHY address, bits 15:0 data. Bits 28:26 always read 0. Bus writes never change bits 29:26.
- R3: A bus write with bit 31 = 1 while `enable_i` is high sets the start flag and launches exactly one frame. A bus write with bit 31 = 0 updates the fields and launches no frame.
- R4: A bus write with bit 31 = 1 while `enable_i` is low leaves the start flag at 0 and launches no frame. The other fields are still written.
- R5: While the start flag reads 1, every bus write is discarded, and the direction, address and data fields keep their values.
- R6: The start flag returns to 0 by itself once the frame completes.
- R7: A write frame is 64 bits, sent MSB first with the output enabled throughout: 32 ones, 01, 01, PHY address, register address, 10, then 16 data bits.
- R8: A read frame sends 32 ones, 01, 10, the PHY address and the register address. MDIO is then released for the last 18 bit times. The 16 bits sampled after the turnaround are stored into bits 15:0.
- R9: After a read, bit 29 is 1 if the PHY drove MDIO low in the second turnaround bit, and 0 otherwise. Write frames leave bit 29 unchanged.
- R10: MDC has a period of 2*HALF_DIV system clocks. MDIO and its output enable change only in the cycle in which MDC falls, and read data is sampled on the rising edge of MDC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Controller enable; the start flag can be set only while this is high |
| wr_en_i | input | 1 | Bus write strobe for the command word |
| wr_data_i | input | 32 | Bus write data |
| rd_data_o | output | 32 | Current command word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data out |
| mdio_oe_o | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO data in from the pad |

## Verification
The hardest case to reach from the ports is a bus write that lands in the middle of a running frame. That write must not disturb the bits already on the wire, and it must leave no trace in the fields once the start flag drops. The bench reaches this case by queuing a read. It then waits a fixed number of clocks, so that the frame is part-way through the preamble, and writes a conflicting word. A behavioural PHY counts MDC edges, checks every driven bit against the expected frame, and answers in the turnaround slot either with or without the low acknowledge. This lets the bench compare the read data and the PHY-answered flag against both outcomes.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int ACK_IDX   = 47;
  localparam int DATA_IDX  = 48;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  typedef struct packed {
    logic        go;
    logic        wr;
    logic        ack;
    logic [2:0]  rsvd;
    logic [4:0]  reg_addr;
    logic [4:0]  phy_addr;
    logic [15:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic fall_tick_o,
  output logic rise_tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // tick marks the clock edge at which mdc toggles
  assign fall_tick_o = wrap & mdc_q;
  assign rise_tick_o = wrap & ~mdc_q;
  assign mdc_o       = mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq import mdio_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fall_tick_i,
  input  logic        rise_tick_i,
  input  logic        go_i,
  input  logic        wr_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] data_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        done_o,
  output logic [15:0] rd_word_o,
  output logic        ack_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] frame;
  logic                 busy_q;
  logic [IDX_W-1:0]     idx_q, nxt_idx, sel;
  logic                 mdio_q, oe_q, ack_q;
  logic [15:0]          shift_q;

  assign frame = {32'hFFFF_FFFF, 2'b01, (wr_i ? 2'b01 : 2'b10), phy_i, reg_i,
                  (wr_i ? 2'b10 : 2'b11), (wr_i ? data_i : 16'hFFFF)};
  assign nxt_idx = idx_q + IDX_W'(1);
  assign sel     = LAST_IDX - nxt_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      mdio_q <= 1'b1;
      oe_q   <= 1'b0;
    end else if (fall_tick_i) begin
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          mdio_q <= frame[FRAME_LEN-1];
          oe_q   <= 1'b1;
        end
      end else if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        mdio_q <= 1'b1;
        oe_q   <= 1'b0;
      end else begin
        idx_q  <= nxt_idx;
        mdio_q <= frame[sel];
        oe_q   <= wr_i | (nxt_idx < IDX_W'(TA_IDX));
      end
    end
  end

  // read side: sample on mdc rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      shift_q <= '0;
    end else if (rise_tick_i && busy_q && !wr_i) begin
      if (idx_q == IDX_W'(ACK_IDX)) ack_q <= ~mdio_i;
      if (idx_q >= IDX_W'(DATA_IDX)) shift_q <= {shift_q[14:0], mdio_i};
    end
  end

  assign done_o    = fall_tick_i & busy_q & (idx_q == LAST_IDX);
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;
  assign rd_word_o = shift_q;
  assign ack_o     = ack_q;
endmodule

// File: rtl/mdio_cmd_reg.sv
`timescale 1ns/1ps
module mdio_cmd_reg import mdio_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        done_i,
  input  logic [15:0] rd_word_i,
  input  logic        ack_i,
  output mdio_cmd_t   cmd_o
);
  mdio_cmd_t cmd_q;
  mdio_cmd_t wr_view;
  logic      unused_bits;

  assign wr_view     = mdio_cmd_t'(wr_data_i);
  assign unused_bits = wr_view.ack ^ (^wr_view.rsvd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (done_i) begin
      cmd_q.go <= 1'b0;
      if (!cmd_q.wr) begin
        cmd_q.data <= rd_word_i;
        cmd_q.ack  <= ack_i;
      end
    end else if (wr_en_i && !cmd_q.go) begin
      cmd_q.go       <= wr_view.go & enable_i;
      cmd_q.wr       <= wr_view.wr;
      cmd_q.reg_addr <= wr_view.reg_addr;
      cmd_q.phy_addr <= wr_view.phy_addr;
      cmd_q.data     <= wr_view.data;
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/mdio_user_ctrl.sv
`timescale 1ns/1ps
module mdio_user_ctrl import mdio_pkg::*; #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        enable_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic        fall_tick, rise_tick, done, ack_s;
  logic [15:0] rd_word;
  mdio_cmd_t   cmd;

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mdc_o       (mdc_o),
    .fall_tick_o (fall_tick),
    .rise_tick_o (rise_tick)
  );

  mdio_cmd_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .done_i    (done),
    .rd_word_i (rd_word),
    .ack_i     (ack_s),
    .cmd_o     (cmd)
  );

  mdio_frame_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_tick_i (fall_tick),
    .rise_tick_i (rise_tick),
    .go_i        (cmd.go),
    .wr_i        (cmd.wr),
    .phy_i       (cmd.phy_addr),
    .reg_i       (cmd.reg_addr),
    .data_i      (cmd.data),
    .mdio_i      (mdio_i),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o),
    .done_o      (done),
    .rd_word_o   (rd_word),
    .ack_o       (ack_s)
  );

  assign rd_data_o = cmd;
endmodule

// File: rtl/mdio_user_ctrl_chk.sv
`timescale 1ns/1ps
module mdio_user_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic [31:0] rd_data_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[28:26] == 3'b000);

  // R4
  go_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !rd_data_o[31]) |=> !rd_data_o[31]);

  // R5
  frozen_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31] |=> $stable({rd_data_o[30], rd_data_o[25:16]}));

  // R10
  mdio_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mdio_o, mdio_oe_o}) |-> $fell(mdc_o));
endmodule

bind mdio_user_ctrl mdio_user_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .rd_data_o (rd_data_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_user_ctrl_test.sv
`timescale 1ns/1ps
module mdio_user_ctrl_test;
  localparam int HALF_DIV = 2;
  // {wr, phy, reg, data, phy_answers}
  localparam int NV = 4;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 5'h01, 5'h00, 16'hA55A, 1'b1},
    {1'b0, 5'h1F, 5'h1F, 16'h3C96, 1'b1},
    {1'b0, 5'h12, 5'h05, 16'h1234, 1'b0},
    {1'b1, 5'h00, 5'h1F, 16'h0001, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // PHY model state
  logic [63:0] rx = '0;
  int          bit_cnt = 0;
  logic        phy_rd = 1'b0;
  logic        phy_ack = 1'b0;
  logic [15:0] phy_data = '0;
  logic        oe_seen = 1'b0;
  logic        ack_model = 1'b0;

  mdio_user_ctrl #(.HALF_DIV(HALF_DIV)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .enable_i  (enable),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .mdc_o     (mdc),
    .mdio_o    (mdio_out),
    .mdio_oe_o (mdio_oe),
    .mdio_i    (mdio_in)
  );

  always #4 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mdio_oe) oe_seen <= 1'b1;
  end

  always @(posedge mdc) begin
    if (mdio_oe && bit_cnt < 64) begin
      rx = {rx[62:0], mdio_out};
      bit_cnt = bit_cnt + 1;
    end else if (!mdio_oe && bit_cnt >= 46 && bit_cnt < 64) begin
      bit_cnt = bit_cnt + 1;
    end
  end

  always @(negedge mdc) begin
    if (phy_rd && bit_cnt == 47) mdio_in = ~phy_ack;
    else if (phy_rd && bit_cnt >= 48 && bit_cnt < 64)
      mdio_in = phy_ack ? phy_data[63 - bit_cnt] : 1'b1;
    else mdio_in = 1'b1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (rd_data[31] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check("R6 go self-clear", {63'd0, rd_data[31]}, 64'd0);
  endtask

  task automatic run_access(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] d, input logic ans, input bit mid_write);
    logic [63:0] exp_f;
    logic [31:0] exp_w;
    bit_cnt = 0;
    rx = '0;
    phy_rd = ~wr;
    phy_ack = ans;
    phy_data = d;
    bus_write({1'b1, wr, 1'b0, 3'b000, rg, phy, d});
    check("R3 go set", {63'd0, rd_data[31]}, 64'd1);
    if (mid_write) begin
      repeat (40) @(negedge clk);
      bus_write(32'h7FFF_FFFF);
      check("R5 go held", {63'd0, rd_data[31]}, 64'd1);
    end
    wait_idle();
    exp_f = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
    check("R10 bit count", 64'(bit_cnt), 64'd64);
    if (wr) begin
      check("R7 write frame", rx, exp_f);
      exp_w = {1'b0, 1'b1, ack_model, 3'b000, rg, phy, d};
      check("R9 ack kept on write", {63'd0, rd_data[29]}, {63'd0, ack_model});
    end else begin
      check("R8 read header", {18'd0, rx[45:0]}, {18'd0, exp_f[63:18]});
      ack_model = ans;
      exp_w = {1'b0, 1'b0, ans, 3'b000, rg, phy, (ans ? d : 16'hFFFF)};
      check("R9 ack", {63'd0, rd_data[29]}, {63'd0, ans});
    end
    check(mid_write ? "R5 fields frozen" : "R8 word after access", {32'd0, rd_data}, {32'd0, exp_w});
  endtask

  initial begin
    #1200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int a, b;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 word", {32'd0, rd_data}, 64'd0);
    check("R1 pins", {61'd0, mdc, mdio_oe, mdio_out}, 64'd1);
    rst_n = 1'b1;

    // R10 mdc period
    @(posedge mdc); a = cyc;
    @(posedge mdc); b = cyc;
    check("R10 mdc period", 64'(b - a), 64'(2 * HALF_DIV));

    // R4 go ignored while disabled, fields still written
    oe_seen = 1'b0;
    bus_write({1'b1, 1'b1, 1'b0, 3'b000, 5'h0A, 5'h03, 16'hBEEF});
    repeat (100) @(negedge clk);
    check("R4 go stays 0", {32'd0, rd_data}, {32'd0, 1'b0, 1'b1, 4'h0, 5'h0A, 5'h03, 16'hBEEF});
    check("R4 no frame", {63'd0, oe_seen}, 64'd0);

    enable = 1'b1;
    // R3 go=0 write: fields only
    oe_seen = 1'b0;
    bus_write({1'b0, 1'b0, 1'b0, 3'b000, 5'h11, 5'h07, 16'h5A5A});
    repeat (100) @(negedge clk);
    check("R3 no go", {32'd0, rd_data}, {32'd0, 2'b00, 4'h0, 5'h11, 5'h07, 16'h5A5A});
    check("R3 no frame", {63'd0, oe_seen}, 64'd0);

    // R2 reserved and ack bits not writable
    bus_write(32'h3C00_0000);
    check("R2 reserved/ack", {60'd0, rd_data[29:26]}, 64'd0);

    for (int i = 0; i < NV; i++)
      run_access(VEC[i][27], VEC[i][26:22], VEC[i][21:17], VEC[i][16:1], VEC[i][0], 1'b0);

    // R5 write during running read is discarded
    run_access(1'b0, 5'h05, 5'h02, 16'hC0DE, 1'b1, 1'b1);
    check("R1 released idle", {63'd0, mdio_oe}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule